// File: doc/BRIEF.md
# Bit-Serial Lookup-Table FIR Filter

This block is an eight-tap low-pass FIR filter for 16-bit two's-complement samples. It has no multiplier. Samples come in over a valid/ready handshake and shift into a delay line. The engine then walks the sixteen bit positions of the stored samples, least significant first, one position per clock.

On each of those clocks, the bit at the current position in every tap forms an 8-bit address. That address selects a precomputed sum of coefficients from a constant table. A shift-right accumulator adds each selected sum, or subtracts it on the sign-bit cycle. The exact 35-bit inner product is then presented together with a one-clock valid pulse.

Back-pressure works only on the input. The block raises `in_ready` only while the serial engine is idle, and a sample is taken on a rising edge where both `in_valid` and `in_ready` are high. The result side has no ready input, so the consumer must take `out_data` when `out_valid` pulses. After that, `out_data` keeps its value until the next result.

Top module: `da_fir`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `in_ready` is 1, `out_valid` is 0 and `out_data` is 0. Reset also empties the delay line, so every earlier sample counts as zero in later results.
- R2: A sample is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 for the 16 cycles that follow that edge.
- R3: `in_valid` and `in_data` have no effect while `in_ready` is 0. Such a sample never enters the delay line, and the result due then is unchanged.
- R4: `out_valid` is 1 for exactly one cycle, the 16th cycle after the accepting edge. `in_ready` is 1 in that same cycle.
- R5: `out_data` is the signed 35-bit value of the sum of c[i]·x[n−i] for i = 0 to 7. Here x[n] is the newest accepted sample, and c = {−327, 1114, 5251, 10345, 10345, 5251, 1114, −327} for i = 0 to 7.
- R6: Bit 15 of a sample carries weight −32768. An input of 16'h8000 counts as −32768, and 16'h7FFF counts as 32767, with no loss of precision.
- R7: `out_data` keeps its value in every cycle where `out_valid` is 0.
- R8: A new sample may be accepted in the same cycle that `out_valid` is 1. This gives one result every 17 cycles when the input is always valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Engine idle; sample taken when in_valid is also 1 |
| in_data | input | 16 | Two's-complement sample |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | 35 | Signed filter output, held between pulses |

## Verification
A result is due exactly 16 cycles after the edge that accepts its sample. The bench counts those cycles itself after each handshake. On every falling edge in between, it confirms that `in_ready` and `out_valid` are low. It reads `out_data` and `in_ready` only on the falling edge after the 16th rising edge, and checks on the following cycle that the pulse has ended and the value is held. Junk samples are offered during the busy window, and offering the next sample in the pulse cycle tests back-to-back acceptance.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  localparam int TAPS_D = 8;
  localparam int DW_D   = 16;
  localparam int CW_D   = 16;

  // Fixed low-pass coefficient set, tap 0 = newest sample.
  function automatic logic signed [CW_D-1:0] coef(input int unsigned i);
    case (i)
      0, 7:    coef = -16'sd327;
      1, 6:    coef = 16'sd1114;
      2, 5:    coef = 16'sd5251;
      3, 4:    coef = 16'sd10345;
      default: coef = '0;
    endcase
  endfunction

  // Sum of the coefficients whose tap bit is set in the address k.
  function automatic logic signed [CW_D+$clog2(TAPS_D)-1:0] psum(input int unsigned k);
    logic signed [CW_D+$clog2(TAPS_D)-1:0] acc;
    logic signed [CW_D-1:0] c;
    acc = '0;
    for (int i = 0; i < TAPS_D; i++) begin
      c = coef(i);
      if (k[i]) acc = acc + {{$clog2(TAPS_D){c[CW_D-1]}}, c};
    end
    return acc;
  endfunction

endpackage

// File: rtl/da_fir_taps.sv
module da_fir_taps #(
  parameter int TAPS = 8,
  parameter int DW   = 16,
  localparam int CNTW = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic [DW-1:0]   din,
  input  logic [CNTW-1:0] bit_idx,
  output logic [TAPS-1:0] slice
);

  logic [DW-1:0] line [TAPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) line[i] <= '0;
    end else if (shift_en) begin
      line[0] <= din;
      for (int i = 1; i < TAPS; i++) line[i] <= line[i-1];
    end
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_slice
    assign slice[g] = line[g][bit_idx];
  end

endmodule

// File: rtl/da_fir_lut.sv
module da_fir_lut #(
  parameter int TAPS = 8,
  parameter int CW   = 16,
  localparam int PW    = CW + $clog2(TAPS),
  localparam int DEPTH = 1 << TAPS
) (
  input  logic [TAPS-1:0]        addr,
  output logic signed [PW-1:0]   part
);

  logic signed [PW-1:0] table_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    assign table_q[k] = da_fir_pkg::psum(k);
  end

  assign part = table_q[addr];

endmodule

// File: rtl/da_fir_ctrl.sv
module da_fir_ctrl #(
  parameter int DW = 16,
  localparam int CNTW = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  output logic            accept,
  output logic            busy,
  output logic            first,
  output logic            last,
  output logic [CNTW-1:0] bit_idx,
  output logic            done
);

  localparam logic [CNTW-1:0] LAST_IDX = CNTW'(DW - 1);

  logic            busy_q;
  logic [CNTW-1:0] cnt_q;
  logic            done_q;

  assign in_ready = !busy_q;
  assign accept   = in_valid && !busy_q;
  assign busy     = busy_q;
  assign bit_idx  = cnt_q;
  assign first    = busy_q && (cnt_q == '0);
  assign last     = busy_q && (cnt_q == LAST_IDX);
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST_IDX) busy_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/da_fir_acc.sv
module da_fir_acc #(
  parameter int TAPS = 8,
  parameter int DW   = 16,
  parameter int CW   = 16,
  localparam int PW = CW + $clog2(TAPS),
  localparam int HW = PW + 1,
  localparam int AW = HW + DW - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy,
  input  logic                 first,
  input  logic                 last,
  input  logic signed [PW-1:0] part,
  output logic [AW-1:0]        result
);

  logic signed [HW-1:0] hi_q;
  logic [DW-1:0]        lo_q;
  logic [AW-1:0]        res_q;

  logic signed [HW-1:0] base;
  logic signed [HW-1:0] part_x;
  logic signed [HW-1:0] sum;
  logic [HW+DW-1:0]     nxt;

  always_comb begin
    base   = first ? '0 : hi_q;
    part_x = {part[PW-1], part};
    sum    = last ? (base - part_x) : (base + part_x);
    nxt    = {sum[HW-1], sum, lo_q[DW-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      res_q <= '0;
    end else if (busy) begin
      hi_q <= nxt[HW+DW-1:DW];
      lo_q <= nxt[DW-1:0];
      if (last) res_q <= nxt[AW-1:0];
    end
  end

  assign result = res_q;

endmodule

// File: rtl/da_fir.sv
module da_fir #(
  parameter int TAPS = da_fir_pkg::TAPS_D,
  parameter int DW   = da_fir_pkg::DW_D,
  parameter int CW   = da_fir_pkg::CW_D
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [DW-1:0]                        in_data,
  output logic                                 out_valid,
  output logic [DW+CW+$clog2(TAPS)-1:0]        out_data
);

  localparam int CNTW = $clog2(DW);
  localparam int PW   = CW + $clog2(TAPS);

  logic                 accept, busy, first, last;
  logic [CNTW-1:0]      bit_idx;
  logic [TAPS-1:0]      slice;
  logic signed [PW-1:0] part;

  da_fir_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .accept(accept), .busy(busy), .first(first), .last(last),
    .bit_idx(bit_idx), .done(out_valid)
  );

  da_fir_taps #(.TAPS(TAPS), .DW(DW)) u_taps (
    .clk(clk), .rst_n(rst_n), .shift_en(accept), .din(in_data),
    .bit_idx(bit_idx), .slice(slice)
  );

  da_fir_lut #(.TAPS(TAPS), .CW(CW)) u_lut (
    .addr(slice), .part(part)
  );

  da_fir_acc #(.TAPS(TAPS), .DW(DW), .CW(CW)) u_acc (
    .clk(clk), .rst_n(rst_n), .busy(busy), .first(first), .last(last),
    .part(part), .result(out_data)
  );

endmodule

// File: rtl/da_fir_chk.sv
module da_fir_chk #(
  parameter int TAPS = 8,
  parameter int DW   = 16,
  parameter int CW   = 16,
  localparam int AW = DW + CW + $clog2(TAPS),
  localparam int KW = $clog2(DW) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_data,
  input logic          out_valid,
  input logic [AW-1:0] out_data
);

  // Cycles since the last accepting edge, saturating back to idle.
  logic [KW-1:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n) since <= '0;
    else if (in_valid && in_ready) since <= KW'(1);
    else if (since != '0 && since < KW'(DW)) since <= since + 1'b1;
    else since <= '0;
  end

  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_busy_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since != '0) |-> !in_ready);

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (since == KW'(DW)) |=> out_valid);

  p_only_when_due_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since == '0) && in_ready);

  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  p_known_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({in_ready, out_valid, out_data}));

endmodule

bind da_fir da_fir_chk #(.TAPS(TAPS), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tb_da_fir.sv
module tb_da_fir;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [34:0] out_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  longint hist [8];
  longint cf [8] = '{-327, 1114, 5251, 10345, 10345, 5251, 1114, -327};

  always #4 clk = ~clk;

  da_fir dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
              .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_out();
    longint s = 0;
    for (int i = 0; i < 8; i++) s += cf[i] * hist[i];
    return s;
  endfunction

  function automatic longint dut_val();
    return longint'($signed(out_data));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    for (int i = 0; i < 8; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid && out_data == '0, "R1", longint'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && out_data == '0, "R1", longint'(out_data), 0);
  endtask

  // Push one sample; optionally offer junk during the busy window (R3).
  task automatic push(input logic [15:0] x, input bit noise, input string req);
    bit busy_bad = 0;
    longint e;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = x;
    @(posedge clk);
    for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = longint'($signed(x));
    @(negedge clk);
    if (noise) begin in_valid = 1'b1; in_data = ~x ^ 16'h5A5A; end
    else in_valid = 1'b0;
    for (int k = 0; k < 16; k++) begin
      if (k > 0) @(negedge clk);
      if (in_ready || out_valid) busy_bad = 1;
    end
    in_valid = 1'b0;
    chk(!busy_bad, "R2", longint'(busy_bad), 0);
    @(negedge clk);
    e = ref_out();
    chk(out_valid && in_ready, "R4", longint'({out_valid, in_ready}), 3);
    chk(dut_val() == e, req, dut_val(), e);
  endtask

  task automatic idle_check();
    longint held = dut_val();
    @(negedge clk);
    chk(!out_valid, "R4", longint'(out_valid), 0);
    chk(dut_val() == held, "R7", dut_val(), held);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) hist[i] = 0;
    do_reset();

    // Impulse through every tap (R5)
    push(16'd1, 0, "R5");
    for (int i = 0; i < 8; i++) push(16'd0, 0, "R5");
    idle_check();
    push(16'd12345, 0, "R5");
    for (int i = 0; i < 7; i++) push(16'd0, 0, "R5");

    // Step to full scale and max negative (R6)
    for (int i = 0; i < 10; i++) push(16'h7FFF, 0, "R6");
    idle_check();
    for (int i = 0; i < 10; i++) push(16'h8000, 0, "R6");
    push(16'hFFFF, 0, "R6");
    for (int i = 0; i < 8; i++) push((i % 2) ? 16'h8000 : 16'h7FFF, 0, "R6");

    // Junk offered while busy must not enter (R3)
    for (int i = 0; i < 12; i++) push(16'(i * 1111 - 7000), 1, "R3");
    idle_check();

    // Back-to-back random stream (R8)
    for (int i = 0; i < 200; i++) push(16'($urandom()), 0, "R8");
    idle_check();

    // Reset in mid-stream clears the delay line (R1)
    for (int i = 0; i < 5; i++) push(16'd30000, 0, "R5");
    do_reset();
    push(16'd1000, 0, "R1");
    idle_check();

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule